// File: doc/BRIEF.md
# Trace Message Queue with Overrun Recovery

This block is the holding queue that sits between several trace message producers and the logic that serializes trace onto pins. Each incoming message carries a payload and a two-bit type tag that names its source: data trace, watchpoint, ownership or branch. Messages enter through a valid/ready push port and leave, in arrival order, through a valid/ready pop port.

When a message is presented while the queue is full, the queue switches into a discard mode. It drops every message offered in that mode and records the type of each one. Meanwhile, everything already stored keeps draining to the output. Once the storage is completely empty, the queue writes one error entry whose payload lists the dropped types, and then returns to normal operation. A one-cycle overrun pulse lets a neighbouring synchronization controller force the next data trace message to carry a full address.

Top module: `trace_msg_queue`

## Requirements
- R1: After reset is released, the queue is empty (`out_valid` low), `in_ready` is high and `ovr_pulse` is low.
- R2: Accepted messages leave in the order they arrived, with type and payload unchanged. `out_valid` is high exactly when the queue holds at least one entry. Ordinary entries have `out_is_err` low.
- R3: The queue stores up to DEPTH entries. In normal mode, while the queue is not full, a push and a pop in the same cycle both take effect.
- R4: In normal mode, a message offered while the queue holds DEPTH entries is dropped and the queue enters discard mode. This holds even if a pop happens in the same cycle.
- R5: `ovr_pulse` is high for exactly one cycle, in the cycle after the message that triggered discard mode. It is low at all other times.
- R6: In discard mode, every offered message is dropped while `in_ready` stays high. The entries already stored keep draining in order.
- R7: In the cycle after discard mode sees an empty queue, `in_ready` is low for one cycle and an error entry is written. From the next cycle that entry is at the output with `out_is_err`=1 and `out_type`=0. Payload bit i is set exactly when a message of type i was dropped during that discard period, and all higher payload bits are zero. Type codes: data=0, watchpoint=1, ownership=2, branch=3.
- R8: Once the error entry is written, normal mode resumes. Later messages are accepted and follow the error entry out.
- R9: A message offered while `in_ready` is low is neither stored nor recorded, so it appears in no later error entry. The record of dropped types is cleared each time an error entry is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A message is offered on the push port |
| in_ready | output | 1 | Push port can take the offered message (low only during error insertion) |
| in_type | input | 2 | Source type of the offered message |
| in_payload | input | 32 | Formatted message payload |
| out_valid | output | 1 | Queue head is valid |
| out_ready | input | 1 | Consumer takes the head this cycle |
| out_is_err | output | 1 | Head is an overrun error entry |
| out_type | output | 2 | Type tag of the head |
| out_payload | output | 32 | Payload of the head (dropped-type mask for error entries) |
| ovr_pulse | output | 1 | One-cycle pulse after an overrun |

## Verification
On every cycle, the assertions check these properties:
- no write lands in a full store;
- nothing is written during discard mode;
- an error write follows one cycle after discard mode sees an empty queue, and normal mode follows that write;
- the overrun pulse only follows a rejected push in normal mode;
- an error entry at the head never carries an empty mask;
- `in_ready` never stays low for two cycles.

Only the bench scenarios can show that payloads keep their order through wrap-around. They also show that the mask is exactly the set of types dropped in one discard period, that a push offered during the insertion cycle leaves no trace in the next error entry, and that a simultaneous pop does not save a push offered to a full queue.

// File: rtl/tmq_pkg.sv
`timescale 1ns/1ps
package tmq_pkg;

    // Width of a formatted trace message body
    localparam int PAYLOAD_W = 32;
    // Number of distinct message sources
    localparam int NTYPE     = 4;
    localparam int TYPE_W    = $clog2(NTYPE);

    typedef enum logic [TYPE_W-1:0] {
        MT_DATA   = 2'd0,
        MT_WPT    = 2'd1,
        MT_OWNER  = 2'd2,
        MT_BRANCH = 2'd3
    } msg_type_e;

    typedef enum logic [1:0] {
        Q_RUN    = 2'd0,
        Q_DRAIN  = 2'd1,
        Q_INJECT = 2'd2
    } q_state_e;

    typedef logic [NTYPE-1:0] type_mask_t;

    typedef struct packed {
        logic                 is_err;
        msg_type_e            mtype;
        logic [PAYLOAD_W-1:0] payload;
    } q_entry_t;

    // Ordinary message entry
    function automatic q_entry_t make_msg(msg_type_e t, logic [PAYLOAD_W-1:0] p);
        q_entry_t e;
        e.is_err  = 1'b0;
        e.mtype   = t;
        e.payload = p;
        return e;
    endfunction

    // Error entry: dropped-type mask in the low payload bits
    function automatic q_entry_t make_err(type_mask_t m);
        q_entry_t e;
        e                    = '0;
        e.is_err             = 1'b1;
        e.mtype              = MT_DATA;
        e.payload[NTYPE-1:0] = m;
        return e;
    endfunction

endpackage

// File: rtl/tmq_ptrs.sv
`timescale 1ns/1ps
// Read/write pointers with one extra wrap bit; DEPTH must be a power of two, at least 2.
module tmq_ptrs #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [ADDR_W-1:0] wr_idx,
    output logic [ADDR_W-1:0] rd_idx,
    output logic              full,
    output logic              empty
);
    localparam int PTR_W = ADDR_W + 1;

    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
        end else if (wr_en) begin
            wr_ptr <= wr_ptr + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
        end else if (rd_en) begin
            rd_ptr <= rd_ptr + PTR_W'(1);
        end
    end

    assign wr_idx = wr_ptr[ADDR_W-1:0];
    assign rd_idx = rd_ptr[ADDR_W-1:0];
    assign empty  = (wr_ptr == rd_ptr);
    assign full   = (wr_ptr[ADDR_W] != rd_ptr[ADDR_W]) &&
                    (wr_ptr[ADDR_W-1:0] == rd_ptr[ADDR_W-1:0]);

endmodule

// File: rtl/tmq_store.sv
`timescale 1ns/1ps
// Entry storage: registered write, combinational read of the head.
module tmq_store
    import tmq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_idx,
    input  q_entry_t          wr_data,
    input  logic [ADDR_W-1:0] rd_idx,
    output q_entry_t          rd_data
);
    q_entry_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/tmq_ovr_ctrl.sv
`timescale 1ns/1ps
// Overrun controller: normal / discard / error-insert sequencing and dropped-type record.
module tmq_ovr_ctrl
    import tmq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  msg_type_e  in_type,
    input  logic       full,
    input  logic       empty,
    output logic       in_ready,
    output logic       wr_en,
    output logic       wr_is_err,
    output type_mask_t err_mask,
    output logic       ovr_pulse,
    output q_state_e   st
);
    q_state_e   st_n;
    logic       discard;
    logic       trigger;
    logic       ovr_q;
    type_mask_t rec_q;

    // A push to a full queue in normal mode opens a discard period
    assign trigger = (st == Q_RUN) && in_valid && full;
    assign discard = trigger || ((st == Q_DRAIN) && in_valid);

    always_comb begin
        st_n      = st;
        in_ready  = 1'b1;
        wr_en     = 1'b0;
        wr_is_err = 1'b0;
        unique case (st)
            Q_RUN: begin
                if (trigger) begin
                    st_n = Q_DRAIN;
                end else if (in_valid) begin
                    wr_en = 1'b1;
                end
            end
            Q_DRAIN: begin
                if (empty) begin
                    st_n = Q_INJECT;
                end
            end
            Q_INJECT: begin
                in_ready  = 1'b0;
                wr_en     = 1'b1;
                wr_is_err = 1'b1;
                st_n      = Q_RUN;
            end
            default: begin
                st_n = Q_RUN;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= Q_RUN;
            ovr_q <= 1'b0;
        end else begin
            st    <= st_n;
            ovr_q <= trigger;
        end
    end

    // One sticky bit per source type; cleared when the error entry is written
    for (genvar g = 0; g < NTYPE; g++) begin : g_rec
        logic hit;
        assign hit = discard && (in_type == msg_type_e'(g));
        always_ff @(posedge clk) begin
            if (rst || (st == Q_INJECT)) begin
                rec_q[g] <= 1'b0;
            end else if (hit) begin
                rec_q[g] <= 1'b1;
            end
        end
    end

    assign err_mask  = rec_q;
    assign ovr_pulse = ovr_q;

endmodule

// File: rtl/trace_msg_queue.sv
`timescale 1ns/1ps
module trace_msg_queue
    import tmq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [TYPE_W-1:0]    in_type,
    input  logic [PAYLOAD_W-1:0] in_payload,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic                 out_is_err,
    output logic [TYPE_W-1:0]    out_type,
    output logic [PAYLOAD_W-1:0] out_payload,
    output logic                 ovr_pulse
);
    localparam int ADDR_W = $clog2(DEPTH);

    logic              wr_en;
    logic              wr_is_err;
    logic              rd_en;
    logic              full;
    logic              empty;
    logic [ADDR_W-1:0] wr_idx;
    logic [ADDR_W-1:0] rd_idx;
    type_mask_t        err_mask;
    q_state_e          st;
    q_entry_t          wr_data;
    q_entry_t          head;

    tmq_ovr_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_type   (msg_type_e'(in_type)),
        .full      (full),
        .empty     (empty),
        .in_ready  (in_ready),
        .wr_en     (wr_en),
        .wr_is_err (wr_is_err),
        .err_mask  (err_mask),
        .ovr_pulse (ovr_pulse),
        .st        (st)
    );

    tmq_ptrs #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ptrs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .wr_idx (wr_idx),
        .rd_idx (rd_idx),
        .full   (full),
        .empty  (empty)
    );

    assign wr_data = wr_is_err ? make_err(err_mask)
                               : make_msg(msg_type_e'(in_type), in_payload);

    tmq_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (head)
    );

    assign out_valid   = !empty;
    assign rd_en       = out_valid && out_ready;
    assign out_is_err  = head.is_err;
    assign out_type    = head.mtype;
    assign out_payload = head.payload;

endmodule

// File: rtl/tmq_chk.sv
`timescale 1ns/1ps
module tmq_chk
    import tmq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input q_state_e   st,
    input logic       full,
    input logic       empty,
    input logic       wr_en,
    input logic       wr_is_err,
    input logic       in_valid,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_is_err,
    input type_mask_t out_mask,
    input logic       ovr_pulse
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && in_ready && !ovr_pulse));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !full);

    assert_ovr_cause_R5: assert property (@(posedge clk) disable iff (rst)
        ovr_pulse |-> $past(in_valid && full && st == Q_RUN));

    assert_drain_no_write_R6: assert property (@(posedge clk) disable iff (rst)
        (st == Q_DRAIN) |-> !wr_en);

    assert_inject_after_empty_R7: assert property (@(posedge clk) disable iff (rst)
        (st == Q_DRAIN && empty) |=> (wr_en && wr_is_err && !in_ready));

    assert_err_mask_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_is_err) |-> (out_mask != '0));

    assert_resume_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_is_err) |=> (st == Q_RUN));

    assert_ready_gap_R9: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> in_ready);

endmodule

bind trace_msg_queue tmq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .st         (st),
    .full       (full),
    .empty      (empty),
    .wr_en      (wr_en),
    .wr_is_err  (wr_is_err),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_is_err (out_is_err),
    .out_mask   (out_payload[tmq_pkg::NTYPE-1:0]),
    .ovr_pulse  (ovr_pulse)
);

// File: tb/trace_msg_queue_tb.sv
`timescale 1ns/1ps
module trace_msg_queue_tb;
    import tmq_pkg::*;

    localparam int DEPTH = 8;
    localparam int EW    = 1 + TYPE_W + PAYLOAD_W;

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 in_valid;
    logic                 in_ready;
    logic [TYPE_W-1:0]    in_type;
    logic [PAYLOAD_W-1:0] in_payload;
    logic                 out_valid;
    logic                 out_ready;
    logic                 out_is_err;
    logic [TYPE_W-1:0]    out_type;
    logic [PAYLOAD_W-1:0] out_payload;
    logic                 ovr_pulse;

    always #4 clk = ~clk;

    trace_msg_queue #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_type(in_type), .in_payload(in_payload),
        .out_valid(out_valid), .out_ready(out_ready), .out_is_err(out_is_err),
        .out_type(out_type), .out_payload(out_payload), .ovr_pulse(ovr_pulse)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference model: 0 normal, 1 discard, 2 error insert
    logic [EW-1:0] mq [$];
    int            mst;
    logic [3:0]    mmask;
    bit            mexp_ovr;

    function automatic logic [EW-1:0] pack_msg(bit e, logic [1:0] t, logic [31:0] p);
        return {e, t, p};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %0h exp %0h", req, what, got, exp);
        end
    endtask

    task automatic model_update(bit v, logic [1:0] t, logic [31:0] p, bit r);
        int  sz;
        bit  pop;
        bit  push;
        logic [EW-1:0] ent;
        sz       = mq.size();
        pop      = (sz > 0) && r;
        push     = 1'b0;
        ent      = '0;
        mexp_ovr = 1'b0;
        case (mst)
            0: if (v) begin
                if (sz == DEPTH) begin
                    mmask[t] = 1'b1;
                    mst      = 1;
                    mexp_ovr = 1'b1;
                end else begin
                    push = 1'b1;
                    ent  = pack_msg(1'b0, t, p);
                end
            end
            1: begin
                if (v) mmask[t] = 1'b1;
                if (sz == 0) mst = 2;
            end
            default: begin
                push  = 1'b1;
                ent   = pack_msg(1'b1, 2'd0, {28'd0, mmask});
                mmask = '0;
                mst   = 0;
            end
        endcase
        if (pop) void'(mq.pop_front());
        if (push) mq.push_back(ent);
    endtask

    // One cycle: drive at negedge, compare, then advance model at posedge
    task automatic step(bit v, logic [1:0] t, logic [31:0] p, bit r);
        logic [EW-1:0] hd;
        @(negedge clk);
        in_valid   = v;
        in_type    = t;
        in_payload = p;
        out_ready  = r;
        #1;
        check("R2", "out_valid", 64'(out_valid), 64'(mq.size() > 0));
        if (mq.size() > 0) begin
            hd = mq[0];
            check(hd[EW-1] ? "R7" : "R2", "out_is_err", 64'(out_is_err), 64'(hd[EW-1]));
            check(hd[EW-1] ? "R7" : "R2", "out_type", 64'(out_type), 64'(hd[PAYLOAD_W +: TYPE_W]));
            check(hd[EW-1] ? "R7" : "R2", "out_payload", 64'(out_payload), 64'(hd[PAYLOAD_W-1:0]));
        end
        check("R9", "in_ready", 64'(in_ready), 64'(mst != 2));
        check("R5", "ovr_pulse", 64'(ovr_pulse), 64'(mexp_ovr));
        @(posedge clk);
        model_update(v, t, p, r);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R2 watchdog got timeout exp finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; in_valid = 1'b0; in_type = '0; in_payload = '0; out_ready = 1'b0;
        mst = 0; mmask = '0; mexp_ovr = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: state right after reset release
        check("R1", "out_valid", 64'(out_valid), 64'd0);
        check("R1", "in_ready", 64'(in_ready), 64'd1);
        check("R1", "ovr_pulse", 64'(ovr_pulse), 64'd0);

        // R3: fill to exactly DEPTH without popping; no overrun
        for (int i = 0; i < DEPTH; i++) step(1'b1, 2'(i), 32'hA000_0000 + i, 1'b0);
        check("R3", "stored entries", 64'(mq.size()), 64'(DEPTH));
        check("R3", "mode after fill", 64'(mst), 64'd0);

        // R4: push to a full queue with a simultaneous pop is still dropped
        step(1'b1, 2'd0, 32'hDEAD_0000, 1'b1);
        check("R4", "mode after full push", 64'(mst), 64'd1);

        // R6: drops during discard mode, types 1 and 3, while draining
        step(1'b1, 2'd1, 32'hDEAD_0001, 1'b1);
        step(1'b1, 2'd3, 32'hDEAD_0003, 1'b0);
        while (mst == 1) step(1'b0, 2'd0, 32'd0, 1'b1);

        // R9: offer type 2 during the insertion cycle
        step(1'b1, 2'd2, 32'hBEEF_0002, 1'b0);
        #1;
        check("R7", "error flag at head", 64'(out_is_err), 64'd1);
        check("R7", "error mask", 64'(out_payload), 64'h0000_000B);

        // R8: normal operation resumes behind the error entry
        step(1'b1, 2'd3, 32'h1234_5678, 1'b1);
        #1;
        check("R8", "resumed head valid", 64'(out_valid), 64'd1);
        check("R8", "resumed head type", 64'(out_type), 64'd3);
        check("R8", "resumed head payload", 64'(out_payload), 64'h1234_5678);

        // R9: second overrun with type 1 only; type 2 from the insert cycle must not appear
        while (mst == 0) step(1'b1, 2'd1, $urandom, 1'b0);
        while (mst == 1) step(1'b0, 2'd0, 32'd0, 1'b1);
        step(1'b0, 2'd0, 32'd0, 1'b0);
        #1;
        check("R9", "second error mask", 64'(out_payload), 64'h0000_0002);

        // Random phases: varying push and pop pressure (R2, R3, R4, R6, R7)
        for (int ph = 0; ph < 12; ph++) begin
            int pv;
            int pr;
            pv = 20 + 15 * (ph % 6);
            pr = 90 - 13 * ((ph * 5) % 7);
            for (int c = 0; c < 200; c++) begin
                step(($urandom_range(99) < pv), 2'($urandom_range(3)), $urandom,
                     ($urandom_range(99) < pr));
            end
        end
        while (mq.size() > 0 || mst != 0) step(1'b0, 2'd0, 32'd0, 1'b1);
        step(1'b0, 2'd0, 32'd0, 1'b1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule